// File: doc/BRIEF.md
# Split-Phase PWM Timer Channel

This block is one channel of a pulse-width timer. It drives a square wave whose high and low phases have separate lengths. Both lengths are written as a single 32-bit reload word that holds two 16-bit minus-one cycle counts. A small control register enables waveform generation and picks the count clock. The count clock is either every cycle of the bus clock, or the rising edges of an asynchronous external tick input. Before use, that tick input is synchronised into the bus-clock domain.

Software converts time periods into cycle counts and writes them through two simple write strobes. A write to the reload word restarts the waveform at once, using the settings present at that moment, and begins with the high phase. If the clock source is changed alone, the waveform is not re-aligned, so the output is undefined until the next reload write. The block has no streaming data path. Every pin is a plain control or status signal, and the block has no valid/ready handshake and applies no back-pressure.

Top module: `pwm_hilo_channel`

## Requirements
- R1: After reset, the control and reload registers both read as zero and `pwm_o` is low. If PWM mode is then entered without any reload write, the output toggles on every count tick.
- R2: In the reload word, bits 31:16 hold the high-phase field and bits 15:0 hold the low-phase field.
- R3: In PWM mode, `pwm_o` stays high for exactly (high field + 1) count ticks.
- R4: In PWM mode, `pwm_o` stays low for exactly (low field + 1) count ticks, and the high and low phases then repeat.
- R5: A field of 0x0000 gives a phase one tick long, and a field of 0xFFFF gives a phase 65536 ticks long.
- R6: Control bits 2:0 are the mode field, and the value 3'b100 selects PWM. With any other mode value, `pwm_o` is held low and the phase counter is held at zero.
- R7: Control bit 3 selects the count clock. The value 1 selects the bus clock, which gives one tick on every `clk` cycle. The value 0 selects the external tick input.
- R8: With the external source selected, each rising edge of `ext_tick_i` gives exactly one count tick, after a fixed synchroniser delay.
- R9: A reload write makes `pwm_o` high in the cycle after the write. It then starts a full high phase built from the newly written fields. This happens even if it interrupts a phase that is still running.
- R10: A control write that moves the mode from a non-PWM value to PWM restarts the waveform in the same way as a reload write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_tick_i | input | 1 | Asynchronous external count clock |
| ctrl_we | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 4 | Control write data: bit 3 selects the clock, bits 2:0 are the mode |
| reload_we | input | 1 | Write strobe for the reload register |
| reload_wdata | input | 32 | Reload write data: high field in 31:16, low field in 15:0 |
| pwm_o | output | 1 | Waveform output |

## Verification
The assertions assume that `ext_tick_i` stays at each level for at least two bus cycles. Under that condition the edge detector never produces ticks on two cycles in a row, and no external edge is lost. The bench drives the external tick from a divider of the bus clock, with a half-period of two to four cycles, so it always meets this rule. It measures the length of each run only after a restart, or on complete phases, so the unknown alignment that follows a source change never reaches a check.

// File: rtl/pwm_hilo_pkg.sv
package pwm_hilo_pkg;
  localparam int PHASE_W  = 16;
  localparam int MODE_W   = 3;
  localparam int CTRL_W   = MODE_W + 1;
  localparam int RELOAD_W = 2 * PHASE_W;
  localparam logic [MODE_W-1:0] MODE_PWM = 3'b100;

  typedef struct packed {
    logic              clk_bus;
    logic [MODE_W-1:0] mode;
  } ctrl_t;
endpackage

// File: rtl/pwm_hilo_regs.sv
module pwm_hilo_regs
  import pwm_hilo_pkg::*;
#(
  parameter int PW = PHASE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic            reload_we,
  input  logic [2*PW-1:0] reload_wdata,
  output ctrl_t           ctrl_q,
  output logic [PW-1:0]   hi_q,
  output logic [PW-1:0]   lo_q,
  output logic            restart_q
);
  ctrl_t wr;
  logic  enter_pwm;

  assign wr        = ctrl_t'(ctrl_wdata);
  assign enter_pwm = ctrl_we && (wr.mode == MODE_PWM) && (ctrl_q.mode != MODE_PWM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      hi_q      <= '0;
      lo_q      <= '0;
      restart_q <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= wr;
      if (reload_we) begin
        hi_q <= reload_wdata[2*PW-1:PW];
        lo_q <= reload_wdata[PW-1:0];
      end
      restart_q <= reload_we | enter_pwm;
    end
  end

  // R10: entering PWM mode always leaves the mode at PWM next cycle
  p_enter_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart_q && !$past(reload_we) |-> ctrl_q.mode == MODE_PWM);
endmodule

// File: rtl/pwm_hilo_tick.sv
module pwm_hilo_tick #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_i,
  input  logic sel_bus,
  output logic tick
);
  localparam int DEPTH = SYNC_STAGES + 1;
  logic [DEPTH-1:0] sh;
  logic             ext_edge;

  generate
    if (DEPTH > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[DEPTH-2:0], ext_i};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= ext_i;
      end
    end
  endgenerate

  assign ext_edge = sh[DEPTH-2] & ~sh[DEPTH-1];
  assign tick     = sel_bus | ext_edge;

  // R8: one synchronised rising edge never yields two adjacent ticks
  p_edge_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_edge |=> !ext_edge);
endmodule

// File: rtl/pwm_hilo_phase.sv
module pwm_hilo_phase #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwm_en,
  input  logic          restart,
  input  logic          tick,
  input  logic [PW-1:0] hi,
  input  logic [PW-1:0] lo,
  output logic          pwm_o
);
  logic [PW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      pwm_o <= 1'b0;
    end else if (!pwm_en) begin
      cnt   <= '0;
      pwm_o <= 1'b0;
    end else if (restart) begin
      cnt   <= hi;
      pwm_o <= 1'b1;
    end else if (tick) begin
      if (cnt == '0) begin
        pwm_o <= ~pwm_o;
        cnt   <= pwm_o ? lo : hi;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_en |=> !pwm_o && cnt == '0);
  p_restart_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_en && restart |=> pwm_o && cnt == $past(hi));
  p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_en && !restart && !tick |=> $stable(pwm_o));
  p_toggle_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_en && !restart && tick && cnt == '0 |=> pwm_o != $past(pwm_o));
endmodule

// File: rtl/pwm_hilo_channel.sv
module pwm_hilo_channel
  import pwm_hilo_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ext_tick_i,
  input  logic                ctrl_we,
  input  logic [CTRL_W-1:0]   ctrl_wdata,
  input  logic                reload_we,
  input  logic [RELOAD_W-1:0] reload_wdata,
  output logic                pwm_o
);
  ctrl_t              ctrl_q;
  logic [PHASE_W-1:0] hi_q;
  logic [PHASE_W-1:0] lo_q;
  logic               restart_q;
  logic               tick;
  logic               pwm_en;

  pwm_hilo_regs #(.PW(PHASE_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_we      (ctrl_we),
    .ctrl_wdata   (ctrl_wdata),
    .reload_we    (reload_we),
    .reload_wdata (reload_wdata),
    .ctrl_q       (ctrl_q),
    .hi_q         (hi_q),
    .lo_q         (lo_q),
    .restart_q    (restart_q)
  );

  pwm_hilo_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_i   (ext_tick_i),
    .sel_bus (ctrl_q.clk_bus),
    .tick    (tick)
  );

  assign pwm_en = (ctrl_q.mode == MODE_PWM);

  pwm_hilo_phase #(.PW(PHASE_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwm_en  (pwm_en),
    .restart (restart_q),
    .tick    (tick),
    .hi      (hi_q),
    .lo      (lo_q),
    .pwm_o   (pwm_o)
  );
endmodule

// File: tb/test_pwm_hilo_channel.sv
module test_pwm_hilo_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_tick_i = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [3:0]  ctrl_wdata = '0;
  logic        reload_we = 1'b0;
  logic [31:0] reload_wdata = '0;
  logic        pwm_o;

  int n_chk = 0;
  int n_fail = 0;
  int ext_half = 2;
  int ext_cnt = 0;
  bit done = 0;

  localparam logic [2:0] PWM = 3'b100;

  always #2 clk = ~clk;

  pwm_hilo_channel i_pwm_hilo_channel (
    .clk(clk), .rst_n(rst_n), .ext_tick_i(ext_tick_i),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .reload_we(reload_we), .reload_wdata(reload_wdata), .pwm_o(pwm_o));

  always @(negedge clk) begin
    if (ext_cnt + 1 >= ext_half) begin
      ext_cnt    <= 0;
      ext_tick_i <= ~ext_tick_i;
    end else ext_cnt <= ext_cnt + 1;
  end

  function automatic int exp_run(int field, int per);
    return (field + 1) * per;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(logic [2:0] mode, logic bus);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = {bus, mode};
    @(negedge clk); ctrl_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_reload(int h, int l);
    @(negedge clk); reload_we = 1'b1; reload_wdata = {h[15:0], l[15:0]};
    @(negedge clk); reload_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_len(output int n);
    logic v;
    v = pwm_o;
    n = 0;
    while (pwm_o == v && n < 70000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n, h, l;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    chk(pwm_o == 1'b0, "R1 reset low", pwm_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(pwm_o == 1'b0, "R1 idle after reset", pwm_o, 0);

    // R1/R10: enter PWM on bus clock with zeroed reload word
    wr_ctrl(PWM, 1'b1);
    chk(pwm_o == 1'b1, "R10 entry drives high", pwm_o, 1);
    run_len(n); chk(n == 1, "R1 zero fields high", n, 1);
    run_len(n); chk(n == 1, "R1 zero fields low", n, 1);

    // R2/R3/R4/R7/R9 directed bus-clock pair
    wr_reload(3, 2);
    run_len(n); chk(n == exp_run(3, 1), "R3 high 3", n, exp_run(3, 1));
    run_len(n); chk(n == exp_run(2, 1), "R4 low 2", n, exp_run(2, 1));
    run_len(n); chk(n == exp_run(3, 1), "R3 repeat high", n, exp_run(3, 1));

    // random bus-clock pairs
    for (int i = 0; i < 6; i++) begin
      h = int'($urandom_range(0, 40));
      l = int'($urandom_range(0, 40));
      wr_reload(h, l);
      run_len(n); chk(n == exp_run(h, 1), "R3 R7 bus high", n, exp_run(h, 1));
      run_len(n); chk(n == exp_run(l, 1), "R4 R2 bus low", n, exp_run(l, 1));
    end

    // R8 external source: complete phases only
    wr_ctrl(PWM, 1'b0);
    for (int i = 0; i < 4; i++) begin
      ext_half = int'($urandom_range(2, 4));
      h = int'($urandom_range(0, 12));
      l = int'($urandom_range(0, 12));
      wr_reload(h, l);
      run_len(n);
      run_len(n); chk(n == exp_run(l, 2*ext_half), "R8 ext low", n, exp_run(l, 2*ext_half));
      run_len(n); chk(n == exp_run(h, 2*ext_half), "R8 ext high", n, exp_run(h, 2*ext_half));
    end

    // R9 reload in the middle of a low phase
    wr_ctrl(PWM, 1'b1);
    wr_reload(10, 10);
    repeat (14) @(negedge clk);
    chk(pwm_o == 1'b0, "R9 in low phase", pwm_o, 0);
    wr_reload(5, 7);
    chk(pwm_o == 1'b1, "R9 restart high", pwm_o, 1);
    run_len(n); chk(n == 6, "R9 new high run", n, 6);
    run_len(n); chk(n == 8, "R9 new low run", n, 8);

    // R6 non-PWM modes hold low
    wr_ctrl(3'b000, 1'b1);
    for (int i = 0; i < 30; i++) begin
      if (pwm_o !== 1'b0) chk(0, "R6 off holds low", pwm_o, 0);
      @(negedge clk);
    end
    chk(pwm_o == 1'b0, "R6 off mode", pwm_o, 0);
    wr_ctrl(3'b101, 1'b1);
    repeat (20) @(negedge clk);
    chk(pwm_o == 1'b0, "R6 other code", pwm_o, 0);
    wr_ctrl(PWM, 1'b1);
    chk(pwm_o == 1'b1, "R10 re-entry high", pwm_o, 1);
    run_len(n); chk(n == 6, "R10 re-entry run", n, 6);

    // R5 extremes
    wr_reload(16'hFFFF, 0);
    run_len(n); chk(n == 65536, "R5 max high", n, 65536);
    run_len(n); chk(n == 1, "R5 min low", n, 1);
    wr_reload(0, 16'hFFFF);
    run_len(n); chk(n == 1, "R5 min high", n, 1);
    run_len(n); chk(n == 65536, "R5 max low", n, 65536);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule